// File: doc/BRIEF.md
# Anti-Pop Soft-Start and Mute Sequencer

This block sits between the modulator of a switching audio amplifier and the gate drivers of its H-bridges. It decides, cycle by cycle, what each half-bridge is asked to do. In power-down the bridges are switched off. When muted, both halves of every bridge are held low, which gives a defined 0 V idle. In play, the modulator bit-stream is passed through differentially. A single system clock, 256 times the audio sample rate by default, paces everything.

When leaving power-down or mute, the block does not switch straight to the bit-stream. It first drives both halves of each bridge with the same square wave. The duty cycle of that wave rises in equal steps from 0 % to 50 %. The filtered output therefore climbs gently from 0 V to mid-supply, and then the modulator takes over at a sample-period boundary. Pulling mute, or the forced-mute request from the protection logic, drops the outputs back to idle on the next clock. This also aborts any ramp in progress. The power-down pin is filtered: a low pulse shorter than a set number of clocks is ignored.

Top module: `popguard_seq`

## Requirements
- R1: While `rst_n` is low, `gate_en`, every `leg_p` bit and every `leg_n` bit are 0.
- R2: Power-down takes effect only once `pdn_n` has been sampled low on PDN_MIN consecutive rising edges. From that edge on, `gate_en`, `leg_p` and `leg_n` are 0. A low run of PDN_MIN-1 edges or fewer leaves the outputs unchanged.
- R3: While in power-down, the mute inputs have no effect and all outputs stay 0. After `pdn_n` is sampled high, the outputs stay 0 for one more cycle. On the second edge the block enters muted idle. If mute is released, the ramp starts on the third edge.
- R4: Muted idle has `gate_en` = 1 and all `leg_p` and `leg_n` bits at 0. It is reached on the first rising edge that samples `mute_n` low, and it holds for as long as a mute request stays active.
- R5: `force_mute` = 1 has the same effect as `mute_n` = 0, whatever the level of `mute_n`.
- R6: During the ramp, `gate_en` = 1 and every `leg_p` and `leg_n` bit carries the same level. The ramp is made of consecutive sample periods of SPC clocks each. Step k runs from 0 to 2^STEPS_LG and is held for STEP_SMP sample periods. In clock j of a period (j from 0), the output is 1 exactly when j < k·(SPC/2)/2^STEPS_LG.
- R7: After the last ramp step (50 % duty), and at a sample boundary, the block plays: `leg_p` = `mod_bits` and `leg_n` = ~`mod_bits`, per channel.
- R8: A mute request during the ramp returns the block to muted idle on the next edge, even when that edge is also a step boundary. The next release restarts the ramp from step 0.
- R9: The ramp runs on leaving mute exactly as it does on leaving power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, SPC times the sample rate |
| rst_n | input | 1 | Asynchronous register reset, active low |
| pdn_n | input | 1 | Power-down request, active low, pulse-filtered |
| mute_n | input | 1 | Mute request, active low |
| force_mute | input | 1 | Mute request from the protection logic, active high |
| mod_bits | input | CH | Modulator bit-stream, one bit per channel |
| gate_en | output | 1 | Enable for the bridge gate drivers |
| leg_p | output | CH | High-side request, positive half of each bridge |
| leg_n | output | CH | High-side request, negative half of each bridge |

## Verification
A mute request and a ramp step advance can land on the same edge. This happens when mute arrives in the last clock of a sample period that closes a step. The bench raises the forced mute exactly there. It then expects muted idle on the next cycle rather than the following step's duty. After release, it expects the full ramp to replay from step 0. It likewise lets a power-down low run end one edge short of the filter limit while play continues, and requires the bit-stream to come through untouched.

// File: rtl/popguard_seq.sv
module popguard_seq #(
  parameter int CH       = 2,
  parameter int SPC      = 256,
  parameter int STEPS_LG = 8,
  parameter int STEP_SMP = 4,
  parameter int PDN_MIN  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pdn_n,
  input  logic          mute_n,
  input  logic          force_mute,
  input  logic [CH-1:0] mod_bits,
  output logic          gate_en,
  output logic [CH-1:0] leg_p,
  output logic [CH-1:0] leg_n
);
  localparam int PW = $clog2(SPC);
  localparam int KW = STEPS_LG + 1;
  localparam int SW = $clog2(STEP_SMP + 1);
  localparam int DW = $clog2(PDN_MIN + 1);
  localparam int MW = KW + PW;
  localparam logic [MW-1:0] HALF_W = MW'(SPC / 2);

  typedef enum logic [1:0] {S_OFF, S_IDLE, S_RAMP, S_PLAY} st_t;

  st_t           st;
  logic          down;
  logic [DW-1:0] dcnt;
  logic [PW-1:0] pos;
  logic [SW-1:0] seg;
  logic [KW-1:0] k;
  logic [MW-1:0] prod, hi_len;
  logic          lvl, mute_req, last_pos, last_seg, last_k;

  assign mute_req = ~mute_n | force_mute;
  assign last_pos = pos == PW'(SPC - 1);
  assign last_seg = seg == SW'(STEP_SMP - 1);
  assign last_k   = k == KW'(2 ** STEPS_LG);
  assign prod     = {{PW{1'b0}}, k} * HALF_W;
  assign hi_len   = prod >> STEPS_LG;
  assign lvl      = {{KW{1'b0}}, pos} < hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      down <= 1'b1;
    end else if (pdn_n) begin
      dcnt <= '0;
      down <= 1'b0;
    end else if (dcnt == DW'(PDN_MIN - 1)) begin
      down <= 1'b1;
    end else begin
      dcnt <= dcnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      pos <= '0;
      seg <= '0;
      k   <= '0;
    end else begin
      if (st != S_RAMP) begin
        pos <= '0;
        seg <= '0;
        k   <= '0;
      end else begin
        pos <= last_pos ? '0 : pos + PW'(1);
        if (last_pos) begin
          seg <= last_seg ? '0 : seg + SW'(1);
          if (last_seg && !last_k) k <= k + KW'(1);
        end
      end
      if (down) st <= S_OFF;
      else begin
        case (st)
          S_OFF:   st <= S_IDLE;
          S_IDLE:  if (!mute_req) st <= S_RAMP;
          S_RAMP:  if (mute_req) st <= S_IDLE;
                   else if (last_pos && last_seg && last_k) st <= S_PLAY;
          default: if (mute_req) st <= S_IDLE;
        endcase
      end
    end
  end

  assign gate_en = ~down & (st != S_OFF);
  assign leg_p = down ? '0 : (st == S_PLAY) ? mod_bits  : (st == S_RAMP) ? {CH{lvl}} : '0;
  assign leg_n = down ? '0 : (st == S_PLAY) ? ~mod_bits : (st == S_RAMP) ? {CH{lvl}} : '0;
endmodule

// File: rtl/popguard_seq_chk.sv
module popguard_seq_chk #(
  parameter int CH      = 2,
  parameter int PDN_MIN = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pdn_n,
  input logic          mute_n,
  input logic          force_mute,
  input logic          gate_en,
  input logic [CH-1:0] leg_p,
  input logic [CH-1:0] leg_n
);
  localparam int DW = $clog2(PDN_MIN + 1);
  logic [DW-1:0] lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= '0;
    else if (pdn_n) lowrun <= '0;
    else if (lowrun != DW'(PDN_MIN)) lowrun <= lowrun + DW'(1);
  end

  // R4
  mute_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_n || force_mute) |=> (leg_p == '0 && leg_n == '0));

  // R6
  legs_matched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((leg_p ^ leg_n) == '0) || ((leg_p ^ leg_n) == '1));

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> (leg_p == '0 && leg_n == '0));

  // R2
  pdn_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> lowrun == DW'(PDN_MIN));
endmodule

bind popguard_seq popguard_seq_chk #(.CH(CH), .PDN_MIN(PDN_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .mute_n(mute_n),
  .force_mute(force_mute), .gate_en(gate_en), .leg_p(leg_p), .leg_n(leg_n)
);

// File: tb/popguard_seq_bench.sv
module popguard_seq_bench;
  localparam int PERIOD   = 10;
  localparam int CH       = 2;
  localparam int SPC      = 8;
  localparam int STEPS_LG = 2;
  localparam int STEP_SMP = 2;
  localparam int PDN_MIN  = 4;
  localparam int RAMP_LEN = (2 ** STEPS_LG + 1) * STEP_SMP * SPC;

  logic clk = 0, rst_n = 0, pdn_n = 0, mute_n = 0, force_mute = 0;
  logic [CH-1:0] bs = '0;
  logic gate_en;
  logic [CH-1:0] leg_p, leg_n;
  int total = 0, bad = 0;

  popguard_seq #(.CH(CH), .SPC(SPC), .STEPS_LG(STEPS_LG), .STEP_SMP(STEP_SMP),
                 .PDN_MIN(PDN_MIN)) u_popguard_seq (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .mute_n(mute_n), .force_mute(force_mute),
    .mod_bits(bs), .gate_en(gate_en), .leg_p(leg_p), .leg_n(leg_n));

  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return 8'({gate_en, leg_n, leg_p});
  endfunction

  task automatic chk_off(string tag);  chk(tag, outs(), 8'h00); endtask
  task automatic chk_idle(string tag); chk(tag, outs(), 8'({1'b1, {2*CH{1'b0}}})); endtask
  task automatic chk_play(string tag); chk(tag, outs(), 8'({1'b1, ~bs, bs})); endtask

  task automatic run_ramp(string tag);
    for (int c = 0; c < RAMP_LEN; c++) begin
      int kk, hl;
      logic lvl;
      @(negedge clk);
      kk  = (c / SPC) / STEP_SMP;
      hl  = (kk * (SPC / 2)) / (2 ** STEPS_LG);
      lvl = (c % SPC) < hl;
      chk(tag, outs(), 8'({1'b1, {CH{lvl}}, {CH{lvl}}}));
    end
    @(negedge clk);
    chk_play("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_off("R1");
    rst_n = 1; mute_n = 1;
    repeat (3) @(negedge clk);
    chk_off("R3");
    pdn_n = 1;
    @(negedge clk); chk_off("R3");
    @(negedge clk); chk_idle("R3");
    bs = 2'b10;
    run_ramp("R6");
    for (int v = 0; v < 4; v++) begin
      bs = CH'(v); #1 chk_play("R7");
      @(negedge clk);
    end
    pdn_n = 0;
    repeat (PDN_MIN - 1) begin
      @(negedge clk); bs = bs + 1'b1; #1 chk_play("R2");
    end
    pdn_n = 1;
    @(negedge clk); chk_play("R2");
    pdn_n = 0;
    repeat (PDN_MIN - 1) @(negedge clk);
    chk_play("R2");
    @(negedge clk); chk_off("R2");
    mute_n = 0;
    @(negedge clk); chk_off("R3");
    mute_n = 1;
    @(negedge clk); chk_off("R3");
    mute_n = 0; pdn_n = 1;
    @(negedge clk); chk_off("R3");
    @(negedge clk); chk_idle("R4");
    repeat (4) begin @(negedge clk); chk_idle("R4"); end
    mute_n = 1;
    run_ramp("R9");
    mute_n = 0;
    @(negedge clk); chk_idle("R4");
    mute_n = 1;
    run_ramp("R9");
    force_mute = 1;
    repeat (3) begin @(negedge clk); chk_idle("R5"); end
    force_mute = 0;
    for (int c = 0; c < 32; c++) @(negedge clk);
    force_mute = 1;
    @(negedge clk); chk_idle("R8");
    force_mute = 0;
    run_ramp("R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule